// File: doc/BRIEF.md
# Master PWM Timer with Trigger Output

This block is an up-counting timer that runs off a programmable clock divider and drives one edge-aligned PWM output. Each counting period ends with an update strobe. A second strobe, the trigger output, is meant for other timers that synchronise to this one. The trigger output carries one of two internal events: the period update, or the moment the counter sits at the compare value.

The configuration arrives as register-style inputs: a divider value, a period limit, a compare threshold, a trigger source select and an enable. While the timer runs, the divider, period and compare settings are shadowed and only refresh at an update, so a period already in progress is never disturbed. While the timer is disabled, the shadows track the inputs, so the first period after enabling uses whatever was set up beforehand. Dropping the enable freezes the timer where it stands, and raising it again resumes from that point.

Top module: `pwm_master_timer`

## Requirements
- R1: With divider value D active, the prescaler emits one count tick every D+1 enabled clock cycles. A tick occurs in any enabled cycle where the prescaler count is at or above D, and the prescaler then restarts from 0.
- R2: On a tick, the counter steps up by one. On a tick where the counter is at or above the active period limit P, the counter returns to 0 instead, and `uev_o` is high for that one cycle. A full period is therefore (P+1)*(D+1) enabled cycles, P may equal the largest counter value, and P=0 gives an update on every tick.
- R3: After reset, the first update comes in the (P+1)*(D+1)-th enabled cycle, counted from the cycle in which the enable first goes high.
- R4: `pwm_o` is high exactly when the timer is enabled and the counter is below the active compare value C. The output is high for C*(D+1) cycles per period, never high for C=0, and always high for C>P.
- R5: The compare event fires in a cycle that has a tick while the counter equals C, once per period when C<=P.
- R6: `trg_sel_i`=0 routes the update strobe to `trgo_o`, and `trg_sel_i`=1 routes the compare event to `trgo_o`. The source that is not selected never appears on `trgo_o`.
- R7: While `en_i` is low, the counter and prescaler hold their values and `pwm_o`, `uev_o` and `trgo_o` are low. When the enable returns, counting resumes from the held state.
- R8: While enabled, new divider, period and compare inputs are copied into the active set only at the clock edge that ends an update cycle. While disabled, the active set follows the inputs every cycle.
- R9: `rst` is synchronous and active high. It clears the counter, the prescaler and the active settings, so with the enable low all outputs are low, and the next enabled run starts at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| div_i | input | PSC_W | Divider value; tick rate is clk/(div_i+1) |
| period_i | input | CNT_W | Period limit; the counter wraps after this value |
| cmp_i | input | CNT_W | Compare threshold for PWM and compare event |
| trg_sel_i | input | 1 | Trigger source: 0 update, 1 compare event |
| pwm_o | output | 1 | Edge-aligned PWM output |
| uev_o | output | 1 | One-cycle update strobe |
| trgo_o | output | 1 | One-cycle trigger strobe for other timers |

## Verification
The bench instantiates the timer with an 8-bit counter and a 4-bit divider. With these widths, a period limit equal to the largest counter value runs a full period in a few hundred cycles, so the wrap at the top of the count range is exercised directly. The narrow widths also keep the divider, compare-above-period and period-shrunk-below-count corners cheap to reach. A cycle-by-cycle reference model feeds the scoreboard, and it is fed with enable pauses, reloads in the middle of a period, and both trigger sources.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        TRG_SEL_UPDATE  = 1'b0,
        TRG_SEL_COMPARE = 1'b1
    } trg_src_e;

    typedef struct packed {
        logic tick;
        logic wrap;
        logic match;
    } tmr_evt_t;

    function automatic trg_src_e to_src(input logic sel);
        return sel ? TRG_SEL_COMPARE : TRG_SEL_UPDATE;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] div_m1,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt_q;

    assign tick = run && (pcnt_q >= div_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             uev,
    input  logic [PSC_W-1:0] div_in,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] cmp_in,
    output logic [PSC_W-1:0] div_q,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] cmp_q
);
    logic load;

    // Transparent while stopped, refreshed at each update while running.
    assign load = !run || uev;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            per_q <= '0;
            cmp_q <= '0;
        end else if (load) begin
            div_q <= div_in;
            per_q <= per_in;
            cmp_q <= cmp_in;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    // At-or-above keeps a shrunk period from running to the top of the range.
    assign wrap = tick && (cnt_q >= per);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int CNT_W = 16
) (
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             pwm,
    output logic             match
);
    assign pwm   = run && (cnt < cmp);
    assign match = tick && (cnt == cmp);
endmodule

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel
    import tmr_pkg::*;
(
    input  tmr_evt_t evt,
    input  trg_src_e src,
    output logic     uev,
    output logic     trgo
);
    assign uev = evt.wrap;

    always_comb begin
        unique case (src)
            TRG_SEL_COMPARE: trgo = evt.match;
            default:         trgo = evt.wrap;
        endcase
    end
endmodule

// File: rtl/pwm_master_timer.sv
module pwm_master_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [PSC_W-1:0] div_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             trg_sel_i,
    output logic             pwm_o,
    output logic             uev_o,
    output logic             trgo_o
);
    logic [PSC_W-1:0] div_act;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             wrap;
    logic             evt_match;
    tmr_evt_t         evt;

    tmr_shadow #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .run    (en_i),
        .uev    (wrap),
        .div_in (div_i),
        .per_in (period_i),
        .cmp_in (cmp_i),
        .div_q  (div_act),
        .per_q  (per_act),
        .cmp_q  (cmp_act)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst    (rst),
        .run    (en_i),
        .div_m1 (div_act),
        .tick   (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .per   (per_act),
        .cnt_q (cnt_q),
        .wrap  (wrap)
    );

    tmr_compare #(.CNT_W(CNT_W)) u_cmp (
        .run   (en_i),
        .tick  (tick),
        .cnt   (cnt_q),
        .cmp   (cmp_act),
        .pwm   (pwm_o),
        .match (evt_match)
    );

    assign evt = '{tick: tick, wrap: wrap, match: evt_match};

    tmr_trig_sel u_trg (
        .evt  (evt),
        .src  (to_src(trg_sel_i)),
        .uev  (uev_o),
        .trgo (trgo_o)
    );
endmodule

// File: rtl/pwm_master_timer_chk.sv
module pwm_master_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             pwm,
    input logic             uev,
    input logic             trgo,
    input logic             cmp_evt,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_act
);
    // R7: stopped timer emits nothing
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!pwm && !uev && !trgo));

    // R7: stopped timer keeps its count
    p_hold_count_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

    // R2: every update returns the counter to zero
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
        uev |=> (cnt == '0));

    // R6: trigger output only carries one of the two internal events
    p_trgo_source_r6: assert property (@(posedge clk) disable iff (rst)
        trgo |-> (uev || cmp_evt));

    // R8: active period only changes at an update while running
    p_shadow_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !uev) |=> $stable(per_act));
endmodule

bind pwm_master_timer pwm_master_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en_i),
    .pwm     (pwm_o),
    .uev     (uev_o),
    .trgo    (trgo_o),
    .cmp_evt (evt_match),
    .cnt     (cnt_q),
    .per_act (per_act)
);

// File: tb/pwm_master_timer_test.sv
module pwm_master_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_i = 1'b0;
    logic [PW-1:0] div_i = '0;
    logic [CW-1:0] period_i = '0;
    logic [CW-1:0] cmp_i = '0;
    logic          trg_sel_i = 1'b0;
    logic          pwm_o, uev_o, trgo_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        bit pwm;
        bit uev;
        bit trgo;
    } exp_t;
    exp_t q[$];

    int m_p, m_c, m_psc, m_arr, m_cmp;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_master_timer #(.CNT_W(CW), .PSC_W(PW)) uut (
        .clk(clk), .rst(rst), .en_i(en_i), .div_i(div_i),
        .period_i(period_i), .cmp_i(cmp_i), .trg_sel_i(trg_sel_i),
        .pwm_o(pwm_o), .uev_o(uev_o), .trgo_o(trgo_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state, advanced at each rising edge
    always @(posedge clk) begin
        bit tk;
        tk = en_i && (m_p >= m_psc);
        if (rst) begin
            m_p <= 0; m_c <= 0; m_psc <= 0; m_arr <= 0; m_cmp <= 0;
        end else if (!en_i) begin
            m_psc <= int'(div_i); m_arr <= int'(period_i); m_cmp <= int'(cmp_i);
        end else if (tk) begin
            m_p <= 0;
            if (m_c >= m_arr) begin
                m_c <= 0;
                m_psc <= int'(div_i); m_arr <= int'(period_i); m_cmp <= int'(cmp_i);
            end else begin
                m_c <= m_c + 1;
            end
        end else begin
            m_p <= m_p + 1;
        end
    end

    // Driver side of the scoreboard: expected outputs for this cycle
    always @(negedge clk) begin
        exp_t e;
        bit tk, mt;
        #1;
        if (mon_on) begin
            tk = en_i && (m_p >= m_psc);
            e.uev = tk && (m_c >= m_arr);
            mt = tk && (m_c == m_cmp);
            e.pwm = en_i && (m_c < m_cmp);
            e.trgo = trg_sel_i ? mt : e.uev;
            q.push_back(e);
        end
    end

    // Monitor side: pop and compare
    always @(negedge clk) begin
        exp_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk("R4 pwm", int'(pwm_o), int'(e.pwm));
            chk("R2 uev", int'(uev_o), int'(e.uev));
            chk("R6 trgo", int'(trgo_o), int'(e.trgo));
        end
    end

    // Counts from the next cycle up to and including the next update cycle
    task automatic to_uev(output int len, output int hi, output int tr);
        len = 0; hi = 0; tr = 0;
        do begin
            @(negedge clk); #3;
            len++;
            hi += int'(pwm_o);
            tr += int'(trgo_o);
        end while (!uev_o && len < 5000);
    endtask

    initial begin
        int len, hi, tr;
        div_i = 4'd3; period_i = 8'd9; cmp_i = 8'd3; trg_sel_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        @(negedge clk); #3;
        chk("R9 pwm after reset", int'(pwm_o), 0);
        chk("R9 uev after reset", int'(uev_o), 0);
        chk("R9 trgo after reset", int'(trgo_o), 0);

        // First update one full period after enable
        @(negedge clk); en_i = 1'b1; #3;
        to_uev(len, hi, tr);
        chk("R3 first update delay", len + 1, 40);

        // Steady period with the update source on the trigger
        to_uev(len, hi, tr);
        chk("R1 R2 period length", len, 40);
        chk("R4 high cycles", hi, 12);
        chk("R6 update trigger count", tr, 1);

        // Compare source on the trigger
        @(negedge clk); trg_sel_i = 1'b1; #3;
        to_uev(len, hi, tr);
        chk("R5 compare events", tr, 1);
        chk("R6 no trigger on update", int'(trgo_o), 0);

        // Pause mid-period and resume
        repeat (10) @(negedge clk);
        en_i = 1'b0; #3;
        chk("R7 pwm low while stopped", int'(pwm_o), 0);
        repeat (5) @(negedge clk);
        en_i = 1'b1; #3;
        to_uev(len, hi, tr);
        chk("R7 resume from held state", len + 1, 31);

        // Reload in mid-period waits for the update
        @(negedge clk); period_i = 8'd4; cmp_i = 8'd2; #3;
        to_uev(len, hi, tr);
        chk("R8 old period kept", len + 1, 40);
        to_uev(len, hi, tr);
        chk("R8 new period", len, 20);
        chk("R8 new duty", hi, 8);

        // Compare at zero and above the period
        @(negedge clk); cmp_i = 8'd0; #3;
        to_uev(len, hi, tr);
        to_uev(len, hi, tr);
        chk("R4 compare zero never high", hi, 0);
        @(negedge clk); cmp_i = 8'd7; #3;
        to_uev(len, hi, tr);
        to_uev(len, hi, tr);
        chk("R4 compare above period always high", hi, 20);

        // Period zero with no division
        @(negedge clk); div_i = 4'd0; period_i = 8'd0; #3;
        to_uev(len, hi, tr);
        to_uev(len, hi, tr);
        chk("R2 period zero update each cycle", len, 1);

        // Largest period limit
        @(negedge clk); period_i = 8'd255; cmp_i = 8'd128; trg_sel_i = 1'b0; #3;
        to_uev(len, hi, tr);
        to_uev(len, hi, tr);
        chk("R2 full-range period", len, 256);
        chk("R4 full-range duty", hi, 128);
        chk("R6 full-range trigger", tr, 1);

        // Period shrunk below the held count while stopped
        repeat (101) @(negedge clk);
        en_i = 1'b0; period_i = 8'd20;
        @(negedge clk); en_i = 1'b1; #3;
        chk("R8 shrunk period wraps at once", int'(uev_o), 1);
        to_uev(len, hi, tr);
        chk("R8 shrunk period length", len, 21);

        // Reset restarts the count
        @(negedge clk); en_i = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; #3;
        chk("R9 outputs low after reset", int'(pwm_o | uev_o | trgo_o), 0);
        @(negedge clk); en_i = 1'b1; #3;
        to_uev(len, hi, tr);
        chk("R9 R3 first update after reset", len + 1, 21);

        @(negedge clk); #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule